// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Port

This block moves stereo audio samples over a three-wire serial link made of a bit clock, a left/right frame clock and one data line in each direction. The receive side turns the incoming stream into a 24-bit parallel sample for each channel and raises a strobe when that channel is complete. The transmit side takes the parallel left and right samples and shifts them out. The bit clock and the frame clock both run in step with the sample rate. Each half-frame is 32 bit clocks long.

A configuration word is captured from the `cfg_*` inputs on a one-cycle `cfg_load` strobe. It selects the framing (I2S, left-justified or right-justified), the word width (24, 16 or 20 bits), the polarity of each clock and the clock role. In slave mode the port follows the clock pins, which it samples with the system clock; that clock must run at least 8 times faster than the bit clock. In master mode the port generates both clocks from the system clock using a programmable divide ratio and enables its clock drivers.

All logic runs on `clk`. The slave pins pass through two-stage synchronizers. Data is launched on the falling edge of the normalized bit clock and sampled on its rising edge.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the configuration is I2S framing, 24-bit words, non-inverted clocks and slave role. After reset `sdata_out`, `rx_valid`, `bclk_out` and `clk_drive_en` are all 0.
- R2: With `cfg_fmt`=0 (I2S), the MSB occupies the second bit clock after a frame-clock edge. A low normalized frame clock marks the left channel.
- R3: With `cfg_fmt`=1 (left-justified), the MSB occupies the first bit clock after the frame-clock edge. A high normalized frame clock marks the left channel.
- R4: With `cfg_fmt`=2 (right-justified), the LSB occupies the last (32nd) bit clock of each half-frame. A high normalized frame clock marks the left channel.
- R5: `cfg_width` selects the word length: 0 gives 24 bits, 1 gives 16 bits, 2 gives 20 bits. Every received word is sign-extended to 24 bits.
- R6: The transmitter sends the low word-length bits of `tx_left`/`tx_right`, MSB first, in the slot that the framing defines. It sends 0 in every other bit position. The sample is taken at the first bit clock of each half-frame.
- R7: `rx_valid` is a one-cycle pulse, issued once for each completed channel word. `rx_is_right` tells which channel was written. No pulse is issued until a frame-clock edge has been seen since the last configuration load.
- R8: `cfg_bclk_inv`=1 inverts the bit-clock pin, so data is launched on rising pin edges and sampled on falling pin edges. `cfg_lr_inv`=1 inverts the frame-clock pin.
- R9: In master mode `clk_drive_en` is 1 and `bclk_out` toggles every `cfg_div`+1 system clocks. `lrclk_out` toggles every 32 bit clocks, in the same cycle as a normalized falling edge of the bit clock.
- R10: Changes on the `cfg_*` inputs have no effect unless `cfg_load` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Captures the cfg_* inputs |
| cfg_fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 treated as I2S |
| cfg_width | input | 2 | 0 selects 24 bits, 1 selects 16 bits, 2 selects 20 bits, 3 selects 24 bits |
| cfg_bclk_inv | input | 1 | Bit-clock pin polarity inversion |
| cfg_lr_inv | input | 1 | Frame-clock pin polarity inversion |
| cfg_master | input | 1 | 1 selects master role |
| cfg_div | input | DIV_W | Bit-clock half period minus one, in system clocks |
| bclk_in | input | 1 | Bit-clock pin in slave mode |
| lrclk_in | input | 1 | Frame-clock pin in slave mode |
| sdata_in | input | 1 | Serial receive data |
| bclk_out | output | 1 | Generated bit clock |
| lrclk_out | output | 1 | Generated frame clock |
| clk_drive_en | output | 1 | Enables the clock pin drivers (master) |
| sdata_out | output | 1 | Serial transmit data |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| rx_left_data | output | 24 | Last received left sample |
| rx_right_data | output | 24 | Last received right sample |
| rx_valid | output | 1 | Channel-complete strobe |
| rx_is_right | output | 1 | Channel of the current strobe |

## Verification
In slave mode a pin edge becomes an internal event two system clocks later. `sdata_out` then updates two further clocks after a falling event, and `rx_valid` rises one clock after the rising event that carries the last bit. The bench holds each bit-clock phase for 8 system clocks, so every check waits well past these latencies. Transmit data is sampled at the last negative clock edge before the next bit-clock rise, and received words are read a few clocks after the final rise of the frame. In master mode, intervals are measured by counting system clocks between `bclk_out` toggles and counting bit-clock rises between `lrclk_out` toggles, with every sample taken at negative clock edges.

// File: rtl/asp_pkg.sv
// Shared constants, the framing enum and the helpers that turn the
// configuration into a word length and a slot start position.
package asp_pkg;
    localparam int SAMPLE_W  = 24;
    localparam int HALF_BITS = 32;
    localparam int POS_W     = $clog2(HALF_BITS);

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } asp_fmt_e;

    // Word length in bits for a width-select code.
    function automatic logic [POS_W:0] word_len(input logic [1:0] wsel);
        case (wsel)
            2'd1:    return (POS_W+1)'(16);
            2'd2:    return (POS_W+1)'(20);
            default: return (POS_W+1)'(SAMPLE_W);
        endcase
    endfunction

    // Half-frame bit position that carries the MSB.
    function automatic logic [POS_W:0] first_pos(input asp_fmt_e fmt,
                                                 input logic [POS_W:0] len);
        case (fmt)
            FMT_LJ:  return '0;
            FMT_RJ:  return (POS_W+1)'(HALF_BITS) - len;
            default: return (POS_W+1)'(1);
        endcase
    endfunction
endpackage

// File: rtl/asp_clkgen.sv
// Bit-clock event source. In master mode the block divides clk to form
// a normalized bit clock. In slave mode it synchronizes the pins and
// detects edges. It also synchronizes the frame clock and serial data.
// Assumes that in slave mode clk runs at least 8x faster than the bit clock.
module asp_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             master,
    input  logic             bclk_inv,
    input  logic [DIV_W-1:0] div,
    input  logic             bclk_pin,
    input  logic             lrclk_pin,
    input  logic             sdata_pin,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             bclk_m,
    output logic             lr_pin_s,
    output logic             sdata_s
);
    logic [2:0]       b_sync;
    logic [1:0]       l_sync;
    logic [1:0]       d_sync;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic             norm_now;
    logic             norm_prev;

    // Two-stage synchronizers, plus one history stage on the bit clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_sync <= '0;
            l_sync <= '0;
            d_sync <= '0;
        end else begin
            b_sync <= {b_sync[1:0], bclk_pin};
            l_sync <= {l_sync[0], lrclk_pin};
            d_sync <= {d_sync[0], sdata_pin};
        end
    end

    // Master divider: toggles the normalized bit clock every div+1 cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !master) begin
            div_cnt <= '0;
            bclk_m  <= 1'b0;
        end else if (tick) begin
            div_cnt <= '0;
            bclk_m  <= ~bclk_m;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Event selection between the divider and the synchronized pin.
    always_comb begin
        tick      = master && (div_cnt == div);
        norm_now  = b_sync[1] ^ bclk_inv;
        norm_prev = b_sync[2] ^ bclk_inv;
        if (master) begin
            rise_ev = tick && !bclk_m;
            fall_ev = tick && bclk_m;
        end else begin
            rise_ev = norm_now && !norm_prev;
            fall_ev = !norm_now && norm_prev;
        end
        lr_pin_s = l_sync[1];
        sdata_s  = d_sync[1];
    end
endmodule

// File: rtl/asp_frame.sv
// Half-frame tracker. On each falling bit-clock event it settles the
// frame-clock level and restarts the bit position at a frame edge
// (saturating otherwise). It also derives the channel. In master mode it
// also generates the frame clock every 32 bit clocks.
module asp_frame
    import asp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             master,
    input  logic             lr_inv,
    input  asp_fmt_e         fmt,
    input  logic             fall_ev,
    input  logic             lr_pin_s,
    output logic [POS_W-1:0] pos_q,
    output logic             right_q,
    output logic             synced_q,
    output logic             lr_m_q
);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(HALF_BITS - 1);

    logic lr_ref_q;
    logic lr_now;
    logic is_i2s;

    // Frame-clock level that applies from this falling event onwards.
    always_comb begin
        is_i2s = (fmt == FMT_I2S) || (fmt == FMT_ALT);
        if (master)
            lr_now = (pos_q == POS_LAST) ? ~lr_m_q : lr_m_q;
        else
            lr_now = lr_pin_s ^ lr_inv;
    end

    // Position, channel, lock and master frame-clock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q    <= POS_LAST;
            right_q  <= 1'b0;
            synced_q <= 1'b0;
            lr_m_q   <= 1'b0;
            lr_ref_q <= 1'b0;
        end else if (restart) begin
            pos_q    <= POS_LAST;
            synced_q <= 1'b0;
        end else if (fall_ev) begin
            if (lr_now != lr_ref_q) begin
                pos_q    <= '0;
                synced_q <= 1'b1;
            end else if (pos_q != POS_LAST) begin
                pos_q <= pos_q + 1'b1;
            end
            lr_ref_q <= lr_now;
            right_q  <= is_i2s ? lr_now : ~lr_now;
            if (master)
                lr_m_q <= lr_now;
        end
    end

    AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(lr_m_q) |-> $past(fall_ev)); // R9
endmodule

// File: rtl/asp_rx.sv
// Receive shifter. On each rising bit-clock event inside the slot it
// shifts one bit in, MSB first. On the slot's last bit it writes the
// sign-extended word to the channel register and pulses rx_valid.
// Assumes pos/right describe the bit now on the line.
module asp_rx
    import asp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise_ev,
    input  logic                sdata_s,
    input  logic [POS_W-1:0]    pos,
    input  logic                right,
    input  logic                synced,
    input  logic [POS_W:0]      start,
    input  logic [POS_W:0]      len,
    output logic [SAMPLE_W-1:0] rx_left,
    output logic [SAMPLE_W-1:0] rx_right,
    output logic                rx_valid,
    output logic                rx_is_right
);
    logic [SAMPLE_W-1:0]        shreg;
    logic [SAMPLE_W-1:0]        full;
    logic [SAMPLE_W-1:0]        shifted;
    logic signed [SAMPLE_W-1:0] ext;
    logic [POS_W:0]             last;
    logic [POS_W:0]             shamt;
    logic [POS_W:0]             len_q;
    logic                       in_slot;
    logic                       at_end;

    // Slot window and sign extension of the word being completed.
    always_comb begin
        last    = start + len - 1'b1;
        in_slot = ({1'b0, pos} >= start) && ({1'b0, pos} <= last);
        at_end  = ({1'b0, pos} == last);
        full    = {shreg[SAMPLE_W-2:0], sdata_s};
        shamt   = (POS_W+1)'(SAMPLE_W) - len;
        shifted = full << shamt;
        ext     = $signed(shifted) >>> shamt;
    end

    // Shift in slot bits and publish the completed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            rx_left     <= '0;
            rx_right    <= '0;
            rx_valid    <= 1'b0;
            rx_is_right <= 1'b0;
            len_q       <= (POS_W+1)'(SAMPLE_W);
        end else begin
            rx_valid <= 1'b0;
            if (rise_ev && synced && in_slot) begin
                shreg <= full;
                if (at_end) begin
                    rx_valid    <= 1'b1;
                    rx_is_right <= right;
                    len_q       <= len;
                    if (right) rx_right <= ext;
                    else       rx_left  <= ext;
                end
            end
        end
    end

    logic signed [SAMPLE_W-1:0] shown_top;
    always_comb shown_top = $signed(rx_is_right ? rx_right : rx_left) >>> (len_q - 1'b1);

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
    AST_VALID_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(synced)); // R7
    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (shown_top == '0 || shown_top == '1)); // R5
endmodule

// File: rtl/asp_tx.sv
// Transmit serializer. One cycle after each falling bit-clock event,
// once the position has settled, it drives the bit for that position.
// It latches the channel's sample at position 0 and drives zero
// outside the slot.
module asp_tx
    import asp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fall_ev,
    input  logic [POS_W-1:0]    pos,
    input  logic                right,
    input  logic [POS_W:0]      start,
    input  logic [POS_W:0]      len,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic                sdata_out
);
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] cur;
    logic [POS_W:0]      rel;
    logic [POS_W-1:0]    idx;
    logic                fall_d;
    logic                hit;
    logic                bit_nxt;

    // Select the word and the bit for the current position.
    always_comb begin
        cur     = (pos == '0) ? (right ? tx_right : tx_left) : word_q;
        rel     = {1'b0, pos} - start;
        hit     = ({1'b0, pos} >= start) && (rel < len);
        idx     = POS_W'(len - 1'b1 - rel);
        bit_nxt = hit ? cur[idx] : 1'b0;
    end

    // Delay the event one cycle, then launch the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fall_d    <= 1'b0;
            word_q    <= '0;
            sdata_out <= 1'b0;
        end else begin
            fall_d <= fall_ev;
            if (fall_d) begin
                if (pos == '0) word_q <= cur;
                sdata_out <= bit_nxt;
            end
        end
    end
endmodule

// File: rtl/audio_serial_port.sv
// Top level: holds the configuration register and joins the clock
// source, frame tracker, receiver and transmitter. Configuration changes
// only on cfg_load, and each load makes the port re-lock to the frame clock.
module audio_serial_port
    import asp_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_load,
    input  logic [1:0]          cfg_fmt,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_bclk_inv,
    input  logic                cfg_lr_inv,
    input  logic                cfg_master,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    output logic                bclk_out,
    output logic                lrclk_out,
    output logic                clk_drive_en,
    output logic                sdata_out,
    input  logic [SAMPLE_W-1:0] tx_left,
    input  logic [SAMPLE_W-1:0] tx_right,
    output logic [SAMPLE_W-1:0] rx_left_data,
    output logic [SAMPLE_W-1:0] rx_right_data,
    output logic                rx_valid,
    output logic                rx_is_right
);
    asp_fmt_e         fmt_q;
    logic [1:0]       wsel_q;
    logic             bclk_inv_q;
    logic             lr_inv_q;
    logic             master_q;
    logic [DIV_W-1:0] div_q;
    logic [POS_W:0]   len;
    logic [POS_W:0]   start;

    logic             rise_ev;
    logic             fall_ev;
    logic             bclk_m;
    logic             lr_pin_s;
    logic             sdata_s;
    logic [POS_W-1:0] pos;
    logic             right;
    logic             synced;
    logic             lr_m;

    // Configuration register, loaded only on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q      <= FMT_I2S;
            wsel_q     <= 2'd0;
            bclk_inv_q <= 1'b0;
            lr_inv_q   <= 1'b0;
            master_q   <= 1'b0;
            div_q      <= '0;
        end else if (cfg_load) begin
            fmt_q      <= asp_fmt_e'(cfg_fmt);
            wsel_q     <= cfg_width;
            bclk_inv_q <= cfg_bclk_inv;
            lr_inv_q   <= cfg_lr_inv;
            master_q   <= cfg_master;
            div_q      <= cfg_div;
        end
    end

    // Slot geometry and the clock pin outputs.
    always_comb begin
        len          = word_len(wsel_q);
        start        = first_pos(fmt_q, len);
        bclk_out     = bclk_m ^ bclk_inv_q;
        lrclk_out    = lr_m ^ lr_inv_q;
        clk_drive_en = master_q;
    end

    asp_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk(clk), .rst_n(rst_n), .restart(cfg_load), .master(master_q),
        .bclk_inv(bclk_inv_q), .div(div_q), .bclk_pin(bclk_in),
        .lrclk_pin(lrclk_in), .sdata_pin(sdata_in), .rise_ev(rise_ev),
        .fall_ev(fall_ev), .bclk_m(bclk_m), .lr_pin_s(lr_pin_s), .sdata_s(sdata_s)
    );

    asp_frame u_frame (
        .clk(clk), .rst_n(rst_n), .restart(cfg_load), .master(master_q),
        .lr_inv(lr_inv_q), .fmt(fmt_q), .fall_ev(fall_ev), .lr_pin_s(lr_pin_s),
        .pos_q(pos), .right_q(right), .synced_q(synced), .lr_m_q(lr_m)
    );

    asp_rx u_rx (
        .clk(clk), .rst_n(rst_n), .rise_ev(rise_ev), .sdata_s(sdata_s),
        .pos(pos), .right(right), .synced(synced), .start(start), .len(len),
        .rx_left(rx_left_data), .rx_right(rx_right_data), .rx_valid(rx_valid),
        .rx_is_right(rx_is_right)
    );

    asp_tx u_tx (
        .clk(clk), .rst_n(rst_n), .fall_ev(fall_ev), .pos(pos), .right(right),
        .start(start), .len(len), .tx_left(tx_left), .tx_right(tx_right),
        .sdata_out(sdata_out)
    );

    AST_TX_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sdata_out) |-> $past(fall_ev, 2)); // R6
endmodule

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;
    localparam int H = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_fmt = 2'd0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_bclk_inv = 1'b0;
    logic        cfg_lr_inv = 1'b0;
    logic        cfg_master = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        bclk_pin = 1'b0;
    logic        lr_pin = 1'b0;
    logic        sd_drv = 1'b0;
    logic        loop_en = 1'b0;
    logic        sdata_in;
    logic        bclk_out, lrclk_out, clk_drive_en, sdata_out;
    logic [23:0] tx_left = '0, tx_right = '0;
    logic [23:0] rx_left_data, rx_right_data;
    logic        rx_valid, rx_is_right;

    int          checks = 0;
    int          fails = 0;
    int          vcount = 0;
    logic [23:0] cap_l = '0, cap_r = '0;
    int          b_fmt = 0, b_len = 24;
    logic        b_binv = 1'b0, b_linv = 1'b0;

    always #5 clk = ~clk;
    assign sdata_in = loop_en ? sdata_out : sd_drv;

    audio_serial_port u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_fmt(cfg_fmt),
        .cfg_width(cfg_width), .cfg_bclk_inv(cfg_bclk_inv), .cfg_lr_inv(cfg_lr_inv),
        .cfg_master(cfg_master), .cfg_div(cfg_div), .bclk_in(bclk_pin),
        .lrclk_in(lr_pin), .sdata_in(sdata_in), .bclk_out(bclk_out),
        .lrclk_out(lrclk_out), .clk_drive_en(clk_drive_en), .sdata_out(sdata_out),
        .tx_left(tx_left), .tx_right(tx_right), .rx_left_data(rx_left_data),
        .rx_right_data(rx_right_data), .rx_valid(rx_valid), .rx_is_right(rx_is_right)
    );

    // Record every completed channel word.
    always @(posedge clk) begin
        if (rx_valid) begin
            vcount <= vcount + 1;
            if (rx_is_right) cap_r <= rx_right_data;
            else             cap_l <= rx_left_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [23:0] w, input int p);
        int off;
        off = (b_fmt == 2) ? 32 - b_len : ((b_fmt == 1) ? 0 : 1);
        if (p >= off && p < off + b_len) return w[b_len - 1 - (p - off)];
        return 1'b0;
    endfunction

    function automatic logic [23:0] sext(input logic [23:0] w, input int len);
        logic [23:0] mask;
        mask = 24'hFFFFFF >> (24 - len);
        return w[len-1] ? ((w & mask) | ~mask) : (w & mask);
    endfunction

    task automatic load(input int fmt, input int wcode, input logic binv,
                        input logic linv, input logic mst, input int div);
        @(negedge clk);
        cfg_fmt = 2'(fmt); cfg_width = 2'(wcode); cfg_bclk_inv = binv;
        cfg_lr_inv = linv; cfg_master = mst; cfg_div = 8'(div);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        b_fmt = fmt; b_binv = binv; b_linv = linv;
        b_len = (wcode == 1) ? 16 : ((wcode == 2) ? 20 : 24);
    endtask

    // One half-frame as an external master, checking sdata_out per bit.
    task automatic half(input logic [23:0] rxw, input logic [23:0] txw,
                        input bit is_right, input string req);
        logic level;
        int   bad_p;
        logic bad_v;
        bad_p = -1; bad_v = 1'b0;
        level = is_right ? (b_fmt == 0 || b_fmt == 3) : !(b_fmt == 0 || b_fmt == 3);
        for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            bclk_pin = b_binv;
            if (p == 0) lr_pin = level ^ b_linv;
            sd_drv = exp_bit(rxw, p);
            repeat (H - 1) @(negedge clk);
            if (sdata_out !== exp_bit(txw, p) && bad_p < 0) begin
                bad_p = p; bad_v = sdata_out;
            end
            @(negedge clk);
            bclk_pin = ~b_binv;
            repeat (H - 1) @(negedge clk);
        end
        check(bad_p < 0, req, bad_p, int'(bad_v));
    endtask

    task automatic preamble();
        logic level;
        level = (b_fmt == 0 || b_fmt == 3);
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            bclk_pin = b_binv;
            lr_pin = level ^ b_linv;
            sd_drv = 1'b0;
            repeat (H - 1) @(negedge clk);
            @(negedge clk);
            bclk_pin = ~b_binv;
            repeat (H - 1) @(negedge clk);
        end
    endtask

    task automatic frame(input logic [23:0] rl, input logic [23:0] rr, input string req);
        int base;
        base = vcount;
        half(rl, tx_left, 1'b0, {req, " tx left slot"});
        half(rr, tx_right, 1'b1, {req, " tx right slot"});
        repeat (6) @(negedge clk);
        check(vcount - base == 2, {req, " R7 one valid per channel"}, vcount - base, 2);
        check(cap_l == sext(rl, b_len), {req, " rx left"}, int'(cap_l), int'(sext(rl, b_len)));
        check(cap_r == sext(rr, b_len), {req, " rx right"}, int'(cap_r), int'(sext(rr, b_len)));
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(sdata_out == 1'b0, "R1 sdata_out reset", int'(sdata_out), 0);
        check(rx_valid == 1'b0, "R1 rx_valid reset", int'(rx_valid), 0);
        check(bclk_out == 1'b0, "R1 bclk_out reset", int'(bclk_out), 0);
        check(clk_drive_en == 1'b0, "R1 clk_drive_en reset", int'(clk_drive_en), 0);
    endtask

    task automatic test_default_i2s();
        tx_left = 24'hA5C3F0; tx_right = 24'h0F1E2D;
        preamble();
        frame(24'h800001, 24'h7FFFFE, "R1 R2 R6 default I2S 24-bit");
    endtask

    task automatic test_lj16();
        load(1, 1, 1'b0, 1'b0, 1'b0, 0);
        tx_left = 24'h12C001; tx_right = 24'h00FFFF;
        preamble();
        frame(24'h008001, 24'h007ABC, "R3 R5 R6 left-justified 16-bit");
    endtask

    task automatic test_rj20();
        load(2, 2, 1'b0, 1'b0, 1'b0, 0);
        tx_left = 24'h0ABCDE; tx_right = 24'hF80001;
        preamble();
        frame(24'h080000, 24'h012345, "R4 R5 R6 right-justified 20-bit");
    endtask

    task automatic test_polarity();
        load(0, 0, 1'b1, 1'b1, 1'b0, 0);
        tx_left = 24'h13579B; tx_right = 24'hFEDCBA;
        preamble();
        frame(24'hC0FFEE, 24'h2468AC, "R8 inverted clocks I2S");
    endtask

    task automatic test_no_load();
        @(negedge clk);
        cfg_fmt = 2'd2; cfg_width = 2'd1; cfg_bclk_inv = 1'b0; cfg_lr_inv = 1'b0;
        tx_left = 24'h600D01; tx_right = 24'h0BAD02;
        frame(24'h111111, 24'hEEEEEE, "R10 inputs changed without load");
    endtask

    task automatic test_master();
        logic prev_b, prev_l;
        int   cnt, gaps, rises;
        int   guard;
        tx_left = 24'h008123; tx_right = 24'h123456;
        loop_en = 1'b1;
        load(1, 1, 1'b0, 1'b0, 1'b1, 4);
        check(clk_drive_en == 1'b1, "R9 clk_drive_en in master", int'(clk_drive_en), 1);
        // Bit-clock toggle interval measured in system clocks.
        gaps = 0; cnt = 0; guard = 0;
        prev_b = bclk_out;
        while (gaps < 3 && guard < 200) begin
            @(negedge clk);
            guard++; cnt++;
            if (bclk_out != prev_b) begin
                if (gaps > 0)
                    check(cnt == 5, "R9 bclk toggle period", cnt, 5);
                gaps++; cnt = 0; prev_b = bclk_out;
            end
        end
        // Bit-clock rises between frame-clock toggles.
        guard = 0;
        prev_l = lrclk_out;
        while (lrclk_out == prev_l && guard < 2000) begin
            @(negedge clk); guard++;
        end
        check(bclk_out == 1'b0, "R9 lrclk moves with bclk fall", int'(bclk_out), 0);
        prev_l = lrclk_out; prev_b = bclk_out; rises = 0; guard = 0;
        while (lrclk_out == prev_l && guard < 2000) begin
            @(negedge clk); guard++;
            if (bclk_out && !prev_b) rises++;
            prev_b = bclk_out;
        end
        check(rises == 32, "R9 bclk rises per half-frame", rises, 32);
        repeat (1500) @(negedge clk);
        check(cap_l == 24'hFF8123, "R9 R3 master loopback left", int'(cap_l), 24'hFF8123);
        check(cap_r == 24'h003456, "R9 R5 master loopback right", int'(cap_r), 24'h003456);
        loop_en = 1'b0;
    endtask

    initial begin
        #(3_000_000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_default_i2s();
        test_lj16();
        test_rj20();
        test_polarity();
        test_no_load();
        test_master();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule